// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous DRAM alive on behalf of a memory controller. Out of reset it holds off for a power-up pause. It then asks for a fixed number of initialization cycles, and every one of them is a refresh. Once those have run it raises a ready flag. From then on a free-running interval timer adds one refresh to a backlog at a steady rate. The rate is chosen so that every row is visited within the retention period.

The controller owns the bus and hands it over through a grant input. While the backlog is non-empty the block holds its request. When it sees the grant it drives the row and column strobes itself. By default it produces column-strobe-before-row-strobe cycles, and back-to-back cycles keep the column strobe low while only the row strobe toggles. A parameter switches the block to row-strobe-only refresh instead. In that mode the column strobe stays high and an internal row counter drives the address. Refreshes that cannot be served at once are counted, and an urgent flag tells the controller when too many are outstanding.

All timing limits are parameters in nanoseconds. They are converted to clock cycles by rounding up, except the refresh interval, which is rounded down so that it is never late.

Top module: `rfsh_sched`

## Requirements
- R1: During reset both strobes are high (inactive) and the request, ready and urgent outputs are 0.
- R2: The request output stays 0 for ceil(PAUSE_NS / clock period) cycles after reset is released, and rises in the cycle that follows.
- R3: When the pause ends, the backlog is loaded with INIT_CYCLES refreshes. The ready output rises only after exactly that many row-strobe pulses, and it then stays high.
- R4: Once ready, one refresh is added every floor(RETENTION_US·10⁶ / CLK_PS / ROWS) cycles.
- R5: In column-first mode, the column strobe is low for at least 5 ns before each row-strobe fall. It stays low for at least 15 ns after the fall, and for the whole time the row strobe is low.
- R6: Every row-strobe low pulse lasts at least 70 ns. Every row-strobe high time between two pulses lasts at least 50 ns.
- R7: When further refreshes are pending and the grant is still held, consecutive column-first cycles keep the column strobe low between row-strobe pulses.
- R8: Without a grant, no new strobe sequence starts and the request stays asserted.
- R9: Unserved refreshes accumulate. The urgent output is 1 exactly when more than POSTPONE_MAX are outstanding, and it returns to 0 once the backlog has been drained.
- R10: In row-only mode the column strobe stays high. The row address output advances by one after each row-strobe pulse, counting from 0, and wraps from ROWS-1 to 0.
- R11: In column-first mode the row address output is held at 0.
- R12: The request output falls only when a refresh completes and leaves the backlog empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Controller has handed the DRAM bus to this block |
| refresh_req | output | 1 | At least one refresh is outstanding |
| refresh_urgent | output | 1 | Backlog exceeds POSTPONE_MAX |
| init_ready | output | 1 | Pause and initialization refreshes are complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W | Refresh row in row-only mode, 0 otherwise |

## Verification
The assertions take for granted that the controller only toggles grant as a level and leaves it high for as long as it wants refreshes to run. They also assume the parameters give every timing window at least one cycle and a refresh interval longer than a worst-case backlog drain. The bench shrinks the pause, retention period and row count so that both modes run many intervals in a short run. It gives and takes away grant only when the block is idle or between whole bursts. It then times every strobe edge against limits it computes itself from the nanosecond figures.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_INIT,
    PH_RUN
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ACT,
    ST_PRE
  } strobe_e;

  // Nanoseconds to clock cycles, rounded up, never below one.
  function automatic int ns_to_cyc(input longint ns, input longint clk_ps);
    longint c;
    c = (ns * 64'd1000 + clk_ps - 64'd1) / clk_ps;
    if (c < 64'd1) c = 64'd1;
    return int'(c);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_timebase.sv
module rfsh_timebase
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 50000,
  parameter int INTERVAL_CYC = 3906
) (
  input  logic clk,
  input  logic rst_n,
  input  logic backlog_empty,
  output logic init_load,
  output logic tick,
  output logic ready
);

  localparam int TW = $clog2(imax(PAUSE_CYC, INTERVAL_CYC) + 1);

  phase_e        phase_q, phase_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    init_load = 1'b0;
    tick      = 1'b0;
    unique case (phase_q)
      PH_PAUSE: begin
        cnt_en = 1'b1;
        if (cnt_q == TW'(PAUSE_CYC - 1)) begin
          init_load = 1'b1;
          phase_d   = PH_INIT;
          cnt_d     = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_INIT: begin
        if (backlog_empty) phase_d = PH_RUN;
      end
      PH_RUN: begin
        cnt_en = 1'b1;
        if (cnt_q == TW'(INTERVAL_CYC - 1)) begin
          tick  = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: phase_d = PH_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PAUSE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign ready = (phase_q == PH_RUN);

  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready) |-> ready);

  a_r3_load_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |-> !ready);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int INIT_CYCLES  = 8,
  parameter int POSTPONE_MAX = 8,
  parameter int BW           = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_load,
  input  logic tick,
  input  logic done,
  output logic pending,
  output logic more,
  output logic urgent
);

  logic [BW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (init_load) begin
      cnt_d = BW'(INIT_CYCLES);
    end else begin
      unique case ({tick, done})
        2'b10:   if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pending = (cnt_q != '0);
  assign more    = (cnt_q > BW'(1));
  assign urgent  = (cnt_q > BW'(POSTPONE_MAX));

  a_r12_req_falls_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(done));

  a_r9_urgent_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(urgent) |-> $past(tick));

endmodule

// File: rtl/rfsh_strobe.sv
module rfsh_strobe
  import rfsh_pkg::*;
#(
  parameter int RAS_ONLY = 0,
  parameter int CSR_CYC  = 2,
  parameter int ACT_CYC  = 18,
  parameter int RAS_CYC  = 18,
  parameter int RP_CYC   = 13,
  parameter int ROWS     = 4096,
  parameter int ROW_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic             more,
  input  logic             grant,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row,
  output logic             done
);

  localparam int MAXC = imax(imax(CSR_CYC, ACT_CYC), RP_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam int KW   = CW + 1;

  strobe_e       state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          chain_q, chain_d;
  logic          ras_n_d, cas_n_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    chain_d = chain_q;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d   = '0;
        chain_d = 1'b0;
        if (pending && grant) state_d = (RAS_ONLY != 0) ? ST_ACT : ST_LEAD;
      end
      ST_LEAD: begin
        if (cnt_q == CW'(CSR_CYC - 1)) begin
          state_d = ST_ACT;
          cnt_d   = '0;
        end
      end
      ST_ACT: begin
        if (cnt_q == CW'(ACT_CYC - 1)) begin
          done    = 1'b1;
          state_d = ST_PRE;
          cnt_d   = '0;
          chain_d = more && grant;
        end
      end
      ST_PRE: begin
        if (cnt_q == CW'(RP_CYC - 1)) begin
          cnt_d   = '0;
          chain_d = 1'b0;
          state_d = (chain_q && grant) ? ST_ACT : ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ras_n_d = (state_d != ST_ACT);
    if (RAS_ONLY != 0) cas_n_d = 1'b1;
    else cas_n_d = !((state_d == ST_LEAD) || (state_d == ST_ACT) ||
                     ((state_d == ST_PRE) && chain_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      chain_q <= 1'b0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      chain_q <= chain_d;
      ras_n   <= ras_n_d;
      cas_n   <= cas_n_d;
    end
  end

  generate
    if (RAS_ONLY != 0) begin : g_row_cnt
      logic [ROW_W-1:0] row_q, row_d;
      always_comb begin
        row_d = row_q;
        if (done) row_d = (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
      end
      assign row = row_q;

      a_r10_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> row == (($past(row) == ROW_W'(ROWS - 1)) ? '0 : $past(row) + 1'b1));

      a_r8_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(grant));
    end else begin : g_row_zero
      assign row = '0;

      a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

      a_r5_cas_low_with_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

      a_r8_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(grant));
    end
  endgenerate

  // Checker: cycles the row strobe has held its present level.
  logic [KW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '1;
    else if (ras_n_d != ras_n) run_q <= KW'(1);
    else if (run_q != '1)      run_q <= run_q + 1'b1;
  end

  a_r6_ras_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $past(run_q) >= KW'(RAS_CYC));

  a_r6_ras_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(run_q) >= KW'(RP_CYC));

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int CLK_PS       = 4000,
  parameter int PAUSE_NS     = 200000,
  parameter int RETENTION_US = 64000,
  parameter int ROWS         = 4096,
  parameter int INIT_CYCLES  = 8,
  parameter int POSTPONE_MAX = 8,
  parameter int RAS_ONLY     = 0,
  parameter int T_CSR_NS     = 5,
  parameter int T_CHR_NS     = 15,
  parameter int T_RAS_NS     = 70,
  parameter int T_RP_NS      = 50,
  localparam int ROW_W       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  output logic             refresh_req,
  output logic             refresh_urgent,
  output logic             init_ready,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row_addr
);

  localparam int     PAUSE_CYC    = ns_to_cyc(longint'(PAUSE_NS), longint'(CLK_PS));
  localparam longint RET_CYC      = (longint'(RETENTION_US) * 64'd1000000) / longint'(CLK_PS);
  localparam int     INTERVAL_CYC = imax(int'(RET_CYC / longint'(ROWS)), 1);
  localparam int     CSR_CYC      = ns_to_cyc(longint'(T_CSR_NS), longint'(CLK_PS));
  localparam int     CHR_CYC      = ns_to_cyc(longint'(T_CHR_NS), longint'(CLK_PS));
  localparam int     RAS_CYC      = ns_to_cyc(longint'(T_RAS_NS), longint'(CLK_PS));
  localparam int     RP_CYC       = ns_to_cyc(longint'(T_RP_NS), longint'(CLK_PS));
  localparam int     ACT_CYC      = (RAS_ONLY != 0) ? RAS_CYC : imax(RAS_CYC, CHR_CYC);
  localparam int     BW           = $clog2(imax(INIT_CYCLES, POSTPONE_MAX) + 2);

  logic init_load, tick, done, more, pending;

  rfsh_timebase #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timebase (
    .clk          (clk),
    .rst_n        (rst_n),
    .backlog_empty(!pending),
    .init_load    (init_load),
    .tick         (tick),
    .ready        (init_ready)
  );

  rfsh_backlog #(
    .INIT_CYCLES (INIT_CYCLES),
    .POSTPONE_MAX(POSTPONE_MAX),
    .BW          (BW)
  ) u_backlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_load(init_load),
    .tick     (tick),
    .done     (done),
    .pending  (pending),
    .more     (more),
    .urgent   (refresh_urgent)
  );

  rfsh_strobe #(
    .RAS_ONLY(RAS_ONLY),
    .CSR_CYC (CSR_CYC),
    .ACT_CYC (ACT_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC),
    .ROWS    (ROWS),
    .ROW_W   (ROW_W)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .pending(pending),
    .more   (more),
    .grant  (grant),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .row    (row_addr),
    .done   (done)
  );

  assign refresh_req = pending;

  a_r2_quiet_until_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_req) && !init_ready |-> $past(init_load));

endmodule

// File: tb/rfsh_sched_tb.sv
`timescale 1ns/1ps
module rfsh_sched_tb;

  localparam int CLK_PS   = 4000;
  localparam int PAUSE_NS = 400;
  localparam int RET_US   = 10;
  localparam int ROWS     = 16;
  localparam int INIT_N   = 8;
  localparam int POST_MAX = 8;
  localparam int PAUSE_CYC = (PAUSE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int INTERVAL  = (RET_US * 1000000 / CLK_PS) / ROWS;
  localparam int CSR_MIN   = (5000 + CLK_PS - 1) / CLK_PS;
  localparam int CHR_MIN   = (15000 + CLK_PS - 1) / CLK_PS;

  logic clk, rst_n, grant_a, grant_b;
  logic req_a, urg_a, ready_a, ras_a, cas_a;
  logic req_b, urg_b, ready_b, ras_b, cas_b;
  logic [3:0] addr_a, addr_b;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;

  rfsh_sched #(.CLK_PS(CLK_PS), .PAUSE_NS(PAUSE_NS), .RETENTION_US(RET_US), .ROWS(ROWS),
               .INIT_CYCLES(INIT_N), .POSTPONE_MAX(POST_MAX), .RAS_ONLY(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .grant(grant_a), .refresh_req(req_a), .refresh_urgent(urg_a),
    .init_ready(ready_a), .ras_n(ras_a), .cas_n(cas_a), .row_addr(addr_a));

  rfsh_sched #(.CLK_PS(CLK_PS), .PAUSE_NS(PAUSE_NS), .RETENTION_US(RET_US), .ROWS(ROWS),
               .INIT_CYCLES(INIT_N), .POSTPONE_MAX(POST_MAX), .RAS_ONLY(1)) u_dut_ro (
    .clk(clk), .rst_n(rst_n), .grant(grant_b), .refresh_req(req_b), .refresh_urgent(urg_b),
    .init_ready(ready_b), .ras_n(ras_b), .cas_n(cas_b), .row_addr(addr_b));

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_req(input bit v, input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (req_a == v) begin
        ok = 1'b1;
        break;
      end
      step();
    end
  endtask

  // Monitor of the column-first instance: strobe timing (R5, R6, R11).
  int a_run, a_cas_low, a_cas_in, a_falls;
  bit a_pras, a_seen_rise;
  always @(negedge clk) begin
    if (!rst_n) begin
      a_run = 0; a_cas_low = 0; a_cas_in = 0; a_falls = 0; a_pras = 1'b1; a_seen_rise = 1'b0;
    end else begin
      if (a_pras && !ras_a) begin
        chk(a_cas_low >= CSR_MIN, "R5 column strobe lead before row fall", a_cas_low, CSR_MIN);
        chk(addr_a == 4'd0, "R11 address held at zero", addr_a, 0);
        if (a_seen_rise)
          chk(a_run * CLK_PS >= 50000, "R6 row strobe high time ps", a_run * CLK_PS, 50000);
        a_falls++;
        a_run = 0;
        a_cas_in = 0;
      end else if (!a_pras && ras_a) begin
        chk(a_run * CLK_PS >= 70000, "R6 row strobe low time ps", a_run * CLK_PS, 70000);
        chk(a_cas_in >= CHR_MIN, "R5 column strobe hold after row fall", a_cas_in, CHR_MIN);
        a_seen_rise = 1'b1;
        a_run = 0;
      end
      a_run++;
      a_cas_low = cas_a ? 0 : a_cas_low + 1;
      if (!ras_a && !cas_a) a_cas_in++;
      a_pras = ras_a;
    end
  end

  // Monitor of the row-only instance (R10).
  int b_exp_row, b_falls;
  bit b_pras, b_wrap;
  always @(negedge clk) begin
    if (!rst_n) begin
      b_exp_row = 0; b_falls = 0; b_pras = 1'b1; b_wrap = 1'b0;
    end else begin
      if (b_pras && !ras_b) begin
        chk(cas_b == 1'b1, "R10 column strobe high in row-only mode", cas_b, 1);
        chk(addr_b == 4'(b_exp_row), "R10 row address sequence", addr_b, b_exp_row);
        if (addr_b == 4'd0 && b_falls >= ROWS) b_wrap = 1'b1;
        b_falls++;
      end else if (!b_pras && ras_b) begin
        b_exp_row = (b_exp_row + 1) % ROWS;
      end
      b_pras = ras_b;
    end
  end

  task automatic t_reset();
    chk(ras_a && cas_a, "R1 strobes idle in reset", {ras_a, cas_a}, 3);
    chk(!req_a && !ready_a && !urg_a, "R1 flags clear in reset", {req_a, ready_a, urg_a}, 0);
    chk(ras_b && cas_b && !req_b && !ready_b, "R1 row-only instance idle in reset",
        {ras_b, cas_b, req_b, ready_b}, 12);
  endtask

  task automatic t_pause();
    int n = 0;
    bit quiet = 1'b1;
    while (!req_a && n < 10 * PAUSE_CYC) begin
      step();
      n++;
      if (!ras_a || !cas_a || ready_a) quiet = 1'b0;
    end
    chk(n == PAUSE_CYC, "R2 pause length in cycles", n, PAUSE_CYC);
    chk(quiet, "R2 no activity during pause", quiet, 1);
  endtask

  task automatic t_no_grant();
    int f0 = a_falls;
    int lows = 0;
    bit held = 1'b1;
    grant_a = 1'b0;
    repeat (50) begin
      step();
      if (!cas_a) lows++;
      if (!req_a) held = 1'b0;
    end
    chk(a_falls == f0 && lows == 0, "R8 no strobe without grant", lows, 0);
    chk(held, "R8 request held without grant", held, 1);
  endtask

  task automatic t_init();
    int f0 = a_falls;
    int n = 0;
    grant_a = 1'b1;
    while (!ready_a && n < 2000) begin
      step();
      n++;
    end
    chk(ready_a, "R3 ready reached", ready_a, 1);
    chk(a_falls - f0 == INIT_N, "R3 initialization refresh count", a_falls - f0, INIT_N);
    chk(!req_a, "R12 request clear after initialization", req_a, 0);
  endtask

  task automatic t_interval();
    bit ok;
    longint c1, c2;
    wait_req(1'b1, 4 * INTERVAL, ok);
    c1 = cyc;
    wait_req(1'b0, 60, ok);
    chk(ok, "R12 request drops after single refresh", ok, 1);
    chk(ready_a, "R3 ready stays high", ready_a, 1);
    wait_req(1'b1, 4 * INTERVAL, ok);
    c2 = cyc;
    chk(c2 - c1 == INTERVAL, "R4 refresh interval in cycles", c2 - c1, INTERVAL);
    wait_req(1'b0, 60, ok);
  endtask

  task automatic t_chain();
    bit ok;
    int f0, gap, cur;
    grant_a = 1'b0;
    wait_req(1'b1, 4 * INTERVAL, ok);
    repeat (2 * INTERVAL + 8) step();
    f0 = a_falls;
    gap = 0;
    grant_a = 1'b1;
    for (int i = 0; i < 400; i++) begin
      step();
      cur = a_falls - f0;
      if (cur >= 1 && cur < 3 && cas_a) gap++;
      if (!req_a) break;
    end
    chk(a_falls - f0 == 3, "R9 three postponed refreshes served", a_falls - f0, 3);
    chk(gap == 0, "R7 column strobe low between chained pulses", gap, 0);
    repeat (3) step();
    chk(cas_a && ras_a, "R7 strobes released after burst", {ras_a, cas_a}, 3);
  endtask

  task automatic t_urgent();
    bit ok;
    int f0;
    wait_req(1'b0, 400, ok);
    grant_a = 1'b0;
    wait_req(1'b1, 4 * INTERVAL, ok);
    f0 = a_falls;
    repeat (8 * INTERVAL - 10) step();
    chk(!urg_a, "R9 urgent clear with eight outstanding", urg_a, 0);
    chk(req_a, "R8 request held while backlog grows", req_a, 1);
    chk(a_falls == f0, "R8 no strobe while grant withheld", a_falls - f0, 0);
    repeat (20) step();
    chk(urg_a, "R9 urgent set with nine outstanding", urg_a, 1);
    grant_a = 1'b1;
    wait_req(1'b0, 3000, ok);
    chk(ok, "R12 request drops after drain", req_a, 0);
    chk(!urg_a, "R9 urgent cleared after drain", urg_a, 0);
    chk(a_falls - f0 >= 9, "R9 backlog drained", a_falls - f0, 9);
  endtask

  task automatic t_rasonly();
    int n = 0;
    while (b_falls < ROWS + 2 && n < 20 * INTERVAL) begin
      step();
      n++;
    end
    chk(b_falls >= ROWS + 2, "R10 row-only refreshes observed", b_falls, ROWS + 2);
    chk(b_wrap, "R10 row counter wrapped to zero", b_wrap, 1);
    chk(!urg_b, "R9 row-only instance not urgent with grant held", urg_b, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    grant_a = 1'b0;
    grant_b = 1'b1;
    repeat (5) step();
    t_reset();
    rst_n = 1'b1;
    t_pause();
    t_no_grant();
    t_init();
    t_interval();
    t_chain();
    t_urgent();
    t_rasonly();
    finish_run();
  end

endmodule